// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flag Update

This block performs the sixteen data-processing operations of a 32-bit integer core in one registered stage. The first operand comes from a register read port and the second comes from an external barrel shifter, which also supplies its own carry-out. The block returns the result, a write strobe for the destination register and the next value of the four condition flags.

The flag update is optional and is selected by the set-flags input. Comparison and test operations always update the flags and never write a register. When a flag-setting operation targets the program counter in a processor mode that owns a saved status word, the block computes no flags. It raises a restore request so that the status register reloads from the saved copy.

The adder can be built as a single wide add or as a two-half carry-select add. A parameter picks the variant.

Top module: `dp_alu`

## Requirements
- R1: The 4-bit opcode selects the operation in this order: 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC, 15 MVN. The arithmetic results are: SUB/CMP = a−b, RSB = b−a, ADD/CMN = a+b, modulo 2^32, where a is `rn_val` and b is `sh_val`.
- R2: The logical results are AND/TST = a&b, EOR/TEQ = a^b, ORR = a|b, MOV = b, BIC = a&~b and MVN = ~b.
- R3: Opcodes 8 to 11 never assert `res_wr_en`, and they update the flags even when `set_flags` is 0. All other valid operations assert `res_wr_en`.
- R4: `flags_in`/`flags_out` pack the flags as bit 3 N, bit 2 Z, bit 1 C, bit 0 V. On a flag-setting logical operation: N is result bit 31; Z is set when the result is zero; C equals `sh_carry`; V is unchanged.
- R5: On a flag-setting addition (ADD, ADC, CMN), C is the unsigned carry out of bit 31 and V is signed overflow.
- R6: On a flag-setting subtraction (SUB, RSB, SBC, RSC, CMP), C is 1 when no borrow occurs and V is signed overflow of the subtraction.
- R7: ADC adds the incoming C. SBC gives a−b−(1−C). RSC gives b−a−(1−C).
- R8: A non-comparison operation with `set_flags` 0 returns `flags_out` equal to `flags_in`.
- R9: A flag-setting operation with `dst_is_pc` and `has_saved_psr` both 1 asserts `restore_psr` and returns `flags_in` unchanged. If either input is 0, `restore_psr` stays 0.
- R10: Results appear one clock after `op_valid`. A cycle without `op_valid` gives `res_valid`, `res_wr_en` and `restore_psr` all 0 on the next cycle.
- R11: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select (see R1) |
| set_flags | input | 1 | Request flag update |
| dst_is_pc | input | 1 | Destination register is the program counter |
| has_saved_psr | input | 1 | Current mode owns a saved status word |
| rn_val | input | DATA_W | First operand |
| sh_val | input | DATA_W | Shifter operand |
| sh_carry | input | 1 | Shifter carry-out |
| flags_in | input | 4 | Current N Z C V |
| res_valid | output | 1 | Result registers hold a new operation |
| res_data | output | DATA_W | Operation result |
| res_wr_en | output | 1 | Write the result to the destination |
| flags_out | output | 4 | Next N Z C V |
| restore_psr | output | 1 | Reload status from the saved word |

## Verification
A corrupted carry-in or a wrong operand inversion in the adder path shows up on `res_data` and on the C/V bits one cycle after the offending operation. The boundary operands 0x7FFFFFFF, 0x80000000, 0−1 and 1−1 expose it at once. A wrong write-enable or restore decode is equally visible on the next cycle, because the registered stage holds no state that carries across operations. The reference model therefore compares every output on every cycle, and the first cycle that differs names the fault.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
      OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
      OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
      OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } alu_flags_t;

   // Comparison and test group: flags only, no register write
   function automatic logic op_is_test(input alu_op_e op);
      return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
   endfunction

   // Operations whose flags come from the adder
   function automatic logic op_is_arith(input alu_op_e op);
      case (op)
         OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/dp_alu_operand_prep.sv
module dp_alu_operand_prep
   import dp_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] rn_val,
   input  logic [DATA_W-1:0] sh_val,
   input  logic              c_in_flag,
   output logic [DATA_W-1:0] add_a,
   output logic [DATA_W-1:0] add_b,
   output logic              add_cin
);

   always_comb begin
      add_a   = rn_val;
      add_b   = sh_val;
      add_cin = 1'b0;
      case (op)
         OP_SUB, OP_CMP: begin
            add_b   = ~sh_val;
            add_cin = 1'b1;
         end
         OP_RSB: begin
            add_a   = sh_val;
            add_b   = ~rn_val;
            add_cin = 1'b1;
         end
         OP_ADC: begin
            add_cin = c_in_flag;
         end
         OP_SBC: begin
            add_b   = ~sh_val;
            add_cin = c_in_flag;
         end
         OP_RSC: begin
            add_a   = sh_val;
            add_b   = ~rn_val;
            add_cin = c_in_flag;
         end
         default: begin
            add_a   = rn_val;
            add_b   = sh_val;
            add_cin = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder #(
   parameter int DATA_W       = 32,
   parameter bit CARRY_SELECT = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout,
   output logic              ovf
);

   localparam int LO_W = DATA_W / 2;
   localparam int HI_W = DATA_W - LO_W;

   generate
      if (CARRY_SELECT) begin : g_csel
         logic [LO_W:0] lo_sum;
         logic [HI_W:0] hi_sum0;
         logic [HI_W:0] hi_sum1;
         logic [HI_W:0] hi_pick;

         assign lo_sum  = {1'b0, a[LO_W-1:0]} + {1'b0, b[LO_W-1:0]} + {{LO_W{1'b0}}, cin};
         assign hi_sum0 = {1'b0, a[DATA_W-1:LO_W]} + {1'b0, b[DATA_W-1:LO_W]};
         assign hi_sum1 = {1'b0, a[DATA_W-1:LO_W]} + {1'b0, b[DATA_W-1:LO_W]}
                          + {{HI_W{1'b0}}, 1'b1};
         assign hi_pick = lo_sum[LO_W] ? hi_sum1 : hi_sum0;
         assign sum     = {hi_pick[HI_W-1:0], lo_sum[LO_W-1:0]};
         assign cout    = hi_pick[HI_W];
      end else begin : g_flat
         logic [DATA_W:0] wide;
         assign wide = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
         assign sum  = wide[DATA_W-1:0];
         assign cout = wide[DATA_W];
      end
   endgenerate

   // Signed overflow: like-signed inputs produce a differently signed sum
   assign ovf = (a[DATA_W-1] == b[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
   import dp_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] rn_val,
   input  logic [DATA_W-1:0] sh_val,
   output logic [DATA_W-1:0] lg_res
);

   always_comb begin
      case (op)
         OP_AND, OP_TST: lg_res = rn_val & sh_val;
         OP_EOR, OP_TEQ: lg_res = rn_val ^ sh_val;
         OP_ORR:         lg_res = rn_val | sh_val;
         OP_MOV:         lg_res = sh_val;
         OP_BIC:         lg_res = rn_val & ~sh_val;
         OP_MVN:         lg_res = ~sh_val;
         default:        lg_res = '0;
      endcase
   end

endmodule

// File: rtl/dp_alu_flag_unit.sv
module dp_alu_flag_unit
   import dp_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  alu_op_e           op,
   input  logic              set_flags,
   input  logic              dst_is_pc,
   input  logic              has_saved_psr,
   input  logic [DATA_W-1:0] result,
   input  logic              add_cout,
   input  logic              add_ovf,
   input  logic              sh_carry,
   input  alu_flags_t        flags_cur,
   output alu_flags_t        flags_nxt,
   output logic              wr_en,
   output logic              restore
);

   logic upd;
   logic arith;

   assign arith   = op_is_arith(op);
   assign upd     = set_flags | op_is_test(op);
   assign restore = upd & dst_is_pc & has_saved_psr;
   assign wr_en   = ~op_is_test(op);

   always_comb begin
      flags_nxt = flags_cur;
      if (upd && !restore) begin
         flags_nxt.n = result[DATA_W-1];
         flags_nxt.z = ~|result;
         if (arith) begin
            flags_nxt.c = add_cout;
            flags_nxt.v = add_ovf;
         end else begin
            flags_nxt.c = sh_carry;
            flags_nxt.v = flags_cur.v;
         end
      end
   end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
   import dp_alu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit CARRY_SELECT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic              set_flags,
   input  logic              dst_is_pc,
   input  logic              has_saved_psr,
   input  logic [DATA_W-1:0] rn_val,
   input  logic [DATA_W-1:0] sh_val,
   input  logic              sh_carry,
   input  logic [3:0]        flags_in,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic              res_wr_en,
   output logic [3:0]        flags_out,
   output logic              restore_psr
);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("dp_alu: DATA_W must be at least 8");
      end
      if (CARRY_SELECT && (DATA_W % 2 != 0)) begin : g_bad_split
         $error("dp_alu: carry-select adder needs an even DATA_W");
      end
   endgenerate

   alu_op_e           op;
   alu_flags_t        cur_flags;
   alu_flags_t        nxt_flags;
   logic [DATA_W-1:0] add_a;
   logic [DATA_W-1:0] add_b;
   logic              add_cin;
   logic [DATA_W-1:0] add_sum;
   logic              add_cout;
   logic              add_ovf;
   logic [DATA_W-1:0] lg_res;
   logic [DATA_W-1:0] alu_res;
   logic              wr_en_c;
   logic              restore_c;

   assign op        = alu_op_e'(op_code);
   assign cur_flags = alu_flags_t'(flags_in);

   dp_alu_operand_prep #(.DATA_W(DATA_W)) i_prep (
      .op        (op),
      .rn_val    (rn_val),
      .sh_val    (sh_val),
      .c_in_flag (cur_flags.c),
      .add_a     (add_a),
      .add_b     (add_b),
      .add_cin   (add_cin)
   );

   dp_alu_adder #(.DATA_W(DATA_W), .CARRY_SELECT(CARRY_SELECT)) i_add (
      .a    (add_a),
      .b    (add_b),
      .cin  (add_cin),
      .sum  (add_sum),
      .cout (add_cout),
      .ovf  (add_ovf)
   );

   dp_alu_logic #(.DATA_W(DATA_W)) i_logic (
      .op     (op),
      .rn_val (rn_val),
      .sh_val (sh_val),
      .lg_res (lg_res)
   );

   assign alu_res = op_is_arith(op) ? add_sum : lg_res;

   dp_alu_flag_unit #(.DATA_W(DATA_W)) i_flags (
      .op            (op),
      .set_flags     (set_flags),
      .dst_is_pc     (dst_is_pc),
      .has_saved_psr (has_saved_psr),
      .result        (alu_res),
      .add_cout      (add_cout),
      .add_ovf       (add_ovf),
      .sh_carry      (sh_carry),
      .flags_cur     (cur_flags),
      .flags_nxt     (nxt_flags),
      .wr_en         (wr_en_c),
      .restore       (restore_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid   <= 1'b0;
         res_data    <= '0;
         res_wr_en   <= 1'b0;
         flags_out   <= '0;
         restore_psr <= 1'b0;
      end else begin
         res_valid   <= op_valid;
         res_wr_en   <= op_valid & wr_en_c;
         restore_psr <= op_valid & restore_c;
         if (op_valid) begin
            res_data  <= alu_res;
            flags_out <= nxt_flags;
         end
      end
   end

endmodule

// File: rtl/dp_alu_checker.sv
module dp_alu_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [3:0]        op_code,
   input logic              set_flags,
   input logic              dst_is_pc,
   input logic              has_saved_psr,
   input logic              sh_carry,
   input logic [3:0]        flags_in,
   input logic              res_valid,
   input logic [DATA_W-1:0] res_data,
   input logic              res_wr_en,
   input logic [3:0]        flags_out,
   input logic              restore_psr
);

   logic is_test;
   logic is_logic;
   logic upd;
   logic rest;

   assign is_test  = (op_code[3:2] == 2'b10);
   assign is_logic = (op_code == 4'h0) || (op_code == 4'h1) || (op_code == 4'h8)
                  || (op_code == 4'h9) || (op_code[3:2] == 2'b11);
   assign upd      = set_flags | is_test;
   assign rest     = upd & dst_is_pc & has_saved_psr;

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> (!res_valid && !res_wr_en && !restore_psr));

   a_r3_test_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && is_test) |=> (res_valid && !res_wr_en));

   a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !upd) |=> (flags_out == $past(flags_in) && !restore_psr));

   a_r9_restore_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && rest) |=> (restore_psr && flags_out == $past(flags_in)));

   a_r4_logic_carry_v: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && upd && !rest && is_logic)
      |=> (flags_out[1] == $past(sh_carry) && flags_out[0] == $past(flags_in[0])));

   a_r4_nz_match_result: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && upd && !rest)
      |=> (flags_out[3] == res_data[DATA_W-1] && flags_out[2] == (res_data == '0)));

endmodule

bind dp_alu dp_alu_checker #(.DATA_W(DATA_W)) i_dp_alu_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .op_valid      (op_valid),
   .op_code       (op_code),
   .set_flags     (set_flags),
   .dst_is_pc     (dst_is_pc),
   .has_saved_psr (has_saved_psr),
   .sh_carry      (sh_carry),
   .flags_in      (flags_in),
   .res_valid     (res_valid),
   .res_data      (res_data),
   .res_wr_en     (res_wr_en),
   .flags_out     (flags_out),
   .restore_psr   (restore_psr)
);

// File: tb/test_dp_alu.sv
module test_dp_alu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_code = '0;
   logic        set_flags = 1'b0;
   logic        dst_is_pc = 1'b0;
   logic        has_saved_psr = 1'b0;
   logic [31:0] rn_val = '0;
   logic [31:0] sh_val = '0;
   logic        sh_carry = 1'b0;
   logic [3:0]  flags_in = '0;
   logic        res_valid;
   logic [31:0] res_data;
   logic        res_wr_en;
   logic [3:0]  flags_out;
   logic        restore_psr;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   dp_alu i_dp_alu (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .set_flags(set_flags), .dst_is_pc(dst_is_pc), .has_saved_psr(has_saved_psr),
      .rn_val(rn_val), .sh_val(sh_val), .sh_carry(sh_carry), .flags_in(flags_in),
      .res_valid(res_valid), .res_data(res_data), .res_wr_en(res_wr_en),
      .flags_out(flags_out), .restore_psr(restore_psr)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Behavioural reference, then one clock, then compare every output
   task automatic run_op(input string req, input int op, input bit s, input bit pc,
                         input bit saved, input logic [31:0] a, input logic [31:0] b,
                         input bit shc, input logic [3:0] fin);
      longint ua, ub, cv, r;
      longint sa, sb, sr;
      logic [31:0] e_res;
      logic [3:0]  e_fl;
      bit e_wr, e_rest, upd, arith, c, v;
      ua = longint'(a); ub = longint'(b); cv = longint'(fin[1]);
      sa = longint'($signed(a)); sb = longint'($signed(b));
      arith = 1'b1; c = 1'b0; sr = 0; r = 0;
      case (op)
         2, 10: begin r = ua - ub;            c = (ua >= ub);          sr = sa - sb; end
         3:     begin r = ub - ua;            c = (ub >= ua);          sr = sb - sa; end
         4, 11: begin r = ua + ub;            c = (r > 64'hFFFFFFFF);  sr = sa + sb; end
         5:     begin r = ua + ub + cv;       c = (r > 64'hFFFFFFFF);  sr = sa + sb + cv; end
         6:     begin r = ua - ub - (1 - cv); c = (ua >= ub + 1 - cv); sr = sa - sb - (1 - cv); end
         7:     begin r = ub - ua - (1 - cv); c = (ub >= ua + 1 - cv); sr = sb - sa - (1 - cv); end
         default: arith = 1'b0;
      endcase
      v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      if (arith) e_res = r[31:0];
      else case (op)
         0, 8:  e_res = a & b;
         1, 9:  e_res = a ^ b;
         12:    e_res = a | b;
         13:    e_res = b;
         14:    e_res = a & ~b;
         default: e_res = ~b;
      endcase
      upd    = s || (op >= 8 && op <= 11);
      e_rest = upd && pc && saved;
      e_wr   = !(op >= 8 && op <= 11);
      e_fl   = fin;
      if (upd && !e_rest)
         e_fl = {e_res[31], e_res == 32'd0, arith ? c : shc, arith ? v : fin[0]};
      op_valid = 1'b1; op_code = 4'(op); set_flags = s; dst_is_pc = pc;
      has_saved_psr = saved; rn_val = a; sh_val = b; sh_carry = shc; flags_in = fin;
      @(negedge clk);
      op_valid = 1'b0;
      check(req, "valid",   {31'd0, res_valid},   32'd1);
      check(req, "result",  res_data,             e_res);
      check(req, "wr_en",   {31'd0, res_wr_en},   {31'd0, e_wr});
      check(req, "flags",   {28'd0, flags_out},   {28'd0, e_fl});
      check(req, "restore", {31'd0, restore_psr}, {31'd0, e_rest});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: outputs held at zero in reset
      check("R11", "valid",   {31'd0, res_valid},   32'd0);
      check("R11", "result",  res_data,             32'd0);
      check("R11", "wr_en",   {31'd0, res_wr_en},   32'd0);
      check("R11", "flags",   {28'd0, flags_out},   32'd0);
      check("R11", "restore", {31'd0, restore_psr}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 and R4: logical operations
      run_op("R2", 0,  1, 0, 0, 32'hF0F0_1234, 32'h0FF0_FFFF, 1, 4'b0001);
      run_op("R2", 1,  1, 0, 0, 32'hAAAA_5555, 32'hAAAA_5555, 0, 4'b0011);
      run_op("R2", 12, 1, 0, 0, 32'h8000_0000, 32'h0000_0001, 1, 4'b0000);
      run_op("R2", 13, 0, 0, 0, 32'h1111_1111, 32'hDEAD_BEEF, 0, 4'b1010);
      run_op("R2", 14, 1, 0, 0, 32'hFFFF_FFFF, 32'h0000_FFFF, 0, 4'b0101);
      run_op("R4", 15, 1, 0, 0, 32'h0,         32'hFFFF_FFFF, 1, 4'b1001);
      // R1 and R5: addition boundaries
      run_op("R5", 4,  1, 0, 0, 32'h7FFF_FFFF, 32'h0000_0001, 0, 4'b0000);
      run_op("R5", 4,  1, 0, 0, 32'hFFFF_FFFF, 32'h0000_0001, 0, 4'b0000);
      run_op("R5", 4,  1, 0, 0, 32'h8000_0000, 32'h8000_0000, 0, 4'b0000);
      run_op("R1", 4,  0, 0, 0, 32'h1234_0000, 32'h0000_5678, 0, 4'b0110);
      // R6: subtraction borrow and overflow
      run_op("R6", 2,  1, 0, 0, 32'h0,         32'h1,         0, 4'b0010);
      run_op("R6", 2,  1, 0, 0, 32'h1,         32'h1,         0, 4'b0000);
      run_op("R6", 2,  1, 0, 0, 32'h8000_0000, 32'h1,         0, 4'b0000);
      run_op("R6", 3,  1, 0, 0, 32'h5,         32'h3,         0, 4'b0000);
      run_op("R6", 3,  1, 0, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 4'b0000);
      // R7: carry-in operations with C set and clear
      run_op("R7", 5,  1, 0, 0, 32'h7FFF_FFFE, 32'h1,         0, 4'b0010);
      run_op("R7", 6,  1, 0, 0, 32'h1,         32'h1,         0, 4'b0000);
      run_op("R7", 6,  1, 0, 0, 32'h1,         32'h1,         0, 4'b0010);
      run_op("R7", 7,  1, 0, 0, 32'h1,         32'h1,         0, 4'b0000);
      run_op("R7", 7,  1, 0, 0, 32'h0,         32'h5,         0, 4'b0010);
      // R3: comparison group with set_flags low
      run_op("R3", 8,  0, 0, 0, 32'hF0,        32'h0F,        1, 4'b0000);
      run_op("R3", 9,  0, 0, 0, 32'h8000_0000, 32'h0,         0, 4'b0001);
      run_op("R3", 10, 0, 0, 0, 32'h0,         32'h1,         0, 4'b0010);
      run_op("R3", 11, 0, 0, 0, 32'h7FFF_FFFF, 32'h1,         0, 4'b0000);
      // R8: no flag update
      run_op("R8", 2,  0, 0, 1, 32'h0,         32'h1,         1, 4'b0101);
      // R9: restore request
      run_op("R9", 4,  1, 1, 1, 32'hFFFF_FFFF, 32'h1,         0, 4'b1010);
      run_op("R9", 10, 0, 1, 1, 32'h0,         32'h1,         0, 4'b0100);
      run_op("R9", 4,  1, 1, 0, 32'hFFFF_FFFF, 32'h1,         0, 4'b1010);
      run_op("R9", 4,  1, 0, 1, 32'hFFFF_FFFF, 32'h1,         0, 4'b1010);
      // R10: idle cycle
      @(negedge clk);
      check("R10", "valid",   {31'd0, res_valid},   32'd0);
      check("R10", "wr_en",   {31'd0, res_wr_en},   32'd0);
      check("R10", "restore", {31'd0, restore_psr}, 32'd0);
      // R1: mixed operands across all opcodes
      for (int k = 0; k < 160; k++) begin
         run_op("R1", k % 16, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
                $urandom_range(0, 1) == 1, $urandom, $urandom,
                $urandom_range(0, 1) == 1, 4'($urandom_range(0, 15)));
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule